// File: doc/BRIEF.md
# Half-Duplex UART with a Single Shared Data Register

This block is one asynchronous serial channel that works in one direction at a time. A mode bit chooses between sending and receiving. In either mode, one 8-bit data register is the only place where software puts or gets a character. A small register port gives access to three locations:

- the data register;
- a control register holding the direction bit and a character length of 5 to 8 bits;
- a status register whose only flag shows that a character is waiting to be sent.

Serial timing comes from an external baud tick that pulses sixteen times per bit. Each bit therefore spans sixteen ticks.

**Sending.** Software writes a character to the data register. A pending flag then rises. The character moves into a shift register as soon as the line is free, which clears the flag.

**Receiving.** A complete frame overwrites the data register. The bits above the chosen length read as zero.

In both directions, the `irq` output pulses for one cycle at the end of each frame.

Top module: `uart_shared_buf`

## Requirements
- R1: After reset the data register reads 00h, the control and status registers read 00h (receive mode, 5-bit length), `txd` is high and `irq` is low.
- R2: In send mode, a write to address 0 stores all 8 written bits, and a read of address 0 returns them unchanged.
- R3: Status bit 0 (pending) is set by an address-0 write in send mode. It clears on the clock after that write when no frame is in progress. If a frame is in progress, it stays set until that frame's stop bit ends.
- R4: A sent frame is one low start bit, then the data bits LSB first, then one high stop bit. Each bit lasts 16 baud ticks, and `txd` is high whenever no frame is in progress.
- R5: Control bits [2:1] select the length: code 0 is 5 bits, 1 is 6, 2 is 7 and 3 is 8. Only that many low bits of the stored character are sent.
- R6: `irq` is high for exactly one cycle after the stop bit of each sent frame.
- R7: In receive mode (control bit 0 = 0), a complete frame on `rxd` loads the received character into the data register and pulses `irq` for one cycle.
- R8: With a 5, 6 or 7-bit length, the received character's unused upper bits read as 0.
- R9: In receive mode, writes to address 0 change neither the data register nor the pending flag, and start no frame on `txd`.
- R10: A low pulse on `rxd` that is back high at the middle of the start bit (8 ticks) is discarded: no `irq` and no change to the data register.
- R11: Frames received back to back each overwrite the data register, which then holds the latest character.
- R12: Writing address 1 sets the direction bit (bit 0, 1 = send) and the length code (bits [2:1]). Both read back from address 1, with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle tick, 16 per bit time |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest state to reach is a second character written while the first is still on the line. In that state the pending flag must hold for a whole frame, and the second frame must follow with no gap. The stimulus writes twice a few cycles apart, then follows the flag and decodes both frames from `txd` at mid-bit.

The other hard cases are a glitch on `rxd` that ends before mid-start, and a 5-bit send whose ignored upper bits would show up as a bad stop bit.

// File: rtl/uart_sb_pkg.sv
package uart_sb_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int CNT_W  = $clog2(OVS);
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } frame_st_e;

    typedef struct packed {
        logic [1:0] len;
        logic       tx;
    } ctrl_t;

    // Index of the last data bit for a length code (0 -> 5 bits ... 3 -> 8 bits)
    function automatic logic [BIT_W-1:0] last_bit(input logic [1:0] code);
        return BIT_W'(4 + int'(code));
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] code);
        return {DATA_W{1'b1}} >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/uart_sb_tx.sv
module uart_sb_tx
    import uart_sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        len_code,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    frame_st_e         st_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic [BIT_W-1:0]  bcnt_q;
    logic [BIT_W-1:0]  last_q;
    logic [DATA_W-1:0] sh_q;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FR_IDLE;
            tcnt_q <= '0;
            bcnt_q <= '0;
            last_q <= '0;
            sh_q   <= '0;
        end else begin
            if (tick) tcnt_q <= tcnt_q + 1'b1;
            case (st_q)
                FR_IDLE: begin
                    if (load) begin
                        st_q   <= FR_START;
                        sh_q   <= load_data;
                        last_q <= last_bit(len_code);
                        tcnt_q <= '0;
                    end
                end
                FR_START: begin
                    if (bit_end) begin
                        st_q   <= FR_DATA;
                        bcnt_q <= '0;
                    end
                end
                FR_DATA: begin
                    if (bit_end) begin
                        sh_q <= sh_q >> 1;
                        if (bcnt_q == last_q) st_q <= FR_STOP;
                        else                  bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                FR_STOP: begin
                    if (bit_end) st_q <= FR_IDLE;
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st_q)
            FR_START: txd = 1'b0;
            FR_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (st_q != FR_IDLE);
    assign done = (st_q == FR_STOP) && bit_end;

endmodule

// File: rtl/uart_sb_rx.sv
module uart_sb_rx
    import uart_sb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              rxd,
    input  logic [1:0]        len_code,
    output logic              strobe,
    output logic [DATA_W-1:0] data
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rx_s;
    frame_st_e              st_q;
    logic [CNT_W-1:0]       tcnt_q;
    logic [BIT_W-1:0]       bcnt_q;
    logic [DATA_W-1:0]      sh_q;
    logic                   bit_end;

    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign bit_end = tick && (tcnt_q == CNT_LAST);

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rxd;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            st_q   <= FR_IDLE;
            tcnt_q <= '0;
            bcnt_q <= '0;
            sh_q   <= '0;
        end else begin
            prev_q <= rx_s;
            if (tick) tcnt_q <= tcnt_q + 1'b1;
            if (!en) begin
                st_q <= FR_IDLE;
            end else begin
                case (st_q)
                    FR_IDLE: begin
                        if (prev_q && !rx_s) begin
                            st_q   <= FR_START;
                            tcnt_q <= '0;
                        end
                    end
                    FR_START: begin
                        if (tick && (tcnt_q == CNT_MID)) begin
                            tcnt_q <= '0;
                            bcnt_q <= '0;
                            sh_q   <= '0;
                            st_q   <= rx_s ? FR_IDLE : FR_DATA;
                        end
                    end
                    FR_DATA: begin
                        if (bit_end) begin
                            sh_q[bcnt_q] <= rx_s;
                            if (bcnt_q == last_bit(len_code)) st_q <= FR_STOP;
                            else                              bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (bit_end) st_q <= FR_IDLE;
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end

    assign strobe = en && (st_q == FR_STOP) && bit_end;
    assign data   = sh_q;

endmodule

// File: rtl/uart_shared_buf.sv
module uart_shared_buf
    import uart_sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] data_buf_q;
    logic              full_q;
    logic              irq_q;
    logic              tx_busy;
    logic              tx_done;
    logic              tx_load;
    logic              rx_strobe;
    logic [DATA_W-1:0] rx_data;
    logic              wr_data;

    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign tx_load = full_q && !tx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            data_buf_q <= '0;
            full_q     <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= tx_done || rx_strobe;
            if (reg_wr && (reg_addr == ADDR_CTRL))
                ctrl_q <= ctrl_t'(reg_wdata[2:0]);
            if (tx_load)
                full_q <= 1'b0;
            if (wr_data && ctrl_q.tx) begin
                data_buf_q <= reg_wdata;
                full_q     <= 1'b1;
            end
            if (rx_strobe)
                data_buf_q <= rx_data;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = data_buf_q;
            ADDR_CTRL: reg_rdata = {{(DATA_W-3){1'b0}}, ctrl_q};
            ADDR_STAT: reg_rdata = {{(DATA_W-1){1'b0}}, full_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = irq_q;

    uart_sb_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .load     (tx_load),
        .load_data(data_buf_q),
        .len_code (ctrl_q.len),
        .txd      (txd),
        .busy     (tx_busy),
        .done     (tx_done)
    );

    uart_sb_rx #(.SYNC_STAGES(2)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .en      (!ctrl_q.tx),
        .rxd     (rxd),
        .len_code(ctrl_q.len),
        .strobe  (rx_strobe),
        .data    (rx_data)
    );

endmodule

// File: rtl/uart_shared_buf_chk.sv
module uart_shared_buf_chk
    import uart_sb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              mode_tx,
    input logic [1:0]        len_code,
    input logic [DATA_W-1:0] data_buf_q,
    input logic              full_q,
    input logic              tx_busy,
    input logic              tx_done,
    input logic              rx_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              txd,
    input logic              irq
);

    AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_DATA && mode_tx) |=> full_q);  // R3

    AST_PENDING_LOADS: assert property (@(posedge clk) disable iff (rst)
        (full_q && !tx_busy) |=> tx_busy);  // R3

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);  // R4

    AST_TX_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);  // R6

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (tx_done || rx_strobe) |=> irq);  // R7

    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |-> ((rx_data & ~len_mask(len_code)) == '0));  // R8

    AST_RX_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_DATA && !mode_tx && !rx_strobe)
            |=> ($stable(data_buf_q) && !full_q));  // R9

endmodule

bind uart_shared_buf uart_shared_buf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .mode_tx   (ctrl_q.tx),
    .len_code  (ctrl_q.len),
    .data_buf_q(data_buf_q),
    .full_q    (full_q),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .rx_strobe (rx_strobe),
    .rx_data   (rx_data),
    .txd       (txd),
    .irq       (irq)
);

// File: tb/uart_shared_buf_bench.sv
`timescale 1ns/1ps
module uart_shared_buf_bench;

    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    int tdiv = 0;

    // behavioural reference state
    bit         model_tx = 0;
    int         model_len = 5;
    logic [7:0] model_buf = 8'h00;
    bit         cmp_en = 0;
    bit         idle_chk = 0;
    bit         irq_prev = 0;
    int         dec_len = 8;
    logic [7:0] dec_q[$];

    uart_shared_buf u_uart_shared_buf (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        baud_tick = (tdiv == 0);
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        #1;
        if (!rst && cmp_en && reg_addr == 2'd0)
            check("R2 per-clock data register", reg_rdata, model_buf);
        if (!rst && idle_chk)
            check("R9 txd idle", {7'b0, txd}, 8'h01);
        if (!rst) begin
            if (irq && irq_prev) check("R6 irq single cycle", 8'h01, 8'h00);
            if (irq) irq_cnt++;
            irq_prev = irq;
        end
    end

    // serial decoder for txd
    initial begin
        bit prev;
        logic [7:0] v;
        prev = 1'b1;
        forever begin
            @(negedge clk); #2;
            if (!rst && prev && !txd) begin
                repeat (BITCLK/2) @(negedge clk);
                #2 check("R4 start bit low", {7'b0, txd}, 8'h00);
                v = 8'h00;
                for (int i = 0; i < dec_len; i++) begin
                    repeat (BITCLK) @(negedge clk);
                    #2 v[i] = txd;
                end
                repeat (BITCLK) @(negedge clk);
                #2 check("R4 R5 stop bit high", {7'b0, txd}, 8'h01);
                dec_q.push_back(v);
            end
            prev = txd;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd1) begin
            model_tx = d[0];
            model_len = 5 + int'(d[2:1]);
        end else if (a == 2'd0 && model_tx) begin
            model_buf = d;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_rx(input logic [7:0] v, input int n);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = v[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int ic;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check("R1 data after reset", r, 8'h00);
        rd(2'd1, r); check("R1 control after reset", r, 8'h00);
        rd(2'd2, r); check("R1 status after reset", r, 8'h00);
        check("R1 txd/irq after reset", {6'b0, txd, irq}, 8'h02);

        // R12 control readback: send mode, 8 bits
        wr(2'd1, 8'hF7);
        rd(2'd1, r); check("R12 control readback", r, 8'h07);
        dec_len = 8;
        reg_addr = 2'd0;
        cmp_en = 1;

        // R2 R3 R4 single character
        ic = irq_cnt;
        wr(2'd0, 8'hA5);
        rd(2'd2, r); check("R3 pending set after write", r, 8'h01);
        @(negedge clk);
        rd(2'd2, r); check("R3 pending cleared on idle load", r, 8'h00);
        reg_addr = 2'd0;
        repeat (700) @(negedge clk);
        check("R4 one frame decoded", 8'(dec_q.size()), 8'h01);
        if (dec_q.size() > 0) check("R4 frame value LSB first", dec_q.pop_front(), 8'hA5);
        check("R6 one irq per sent frame", 8'(irq_cnt - ic), 8'h01);

        // R3 back-to-back
        ic = irq_cnt;
        wr(2'd0, 8'h3C);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'hC3);
        repeat (100) @(negedge clk);
        rd(2'd2, r); check("R3 pending held during frame", r, 8'h01);
        reg_addr = 2'd0;
        repeat (1400) @(negedge clk);
        rd(2'd2, r); check("R3 pending cleared after frame", r, 8'h00);
        reg_addr = 2'd0;
        check("R3 two frames decoded", 8'(dec_q.size()), 8'h02);
        if (dec_q.size() > 1) begin
            check("R3 first frame", dec_q.pop_front(), 8'h3C);
            check("R3 second frame", dec_q.pop_front(), 8'hC3);
        end
        check("R6 two irqs", 8'(irq_cnt - ic), 8'h02);
        rd(2'd0, r); check("R2 readback latest", r, 8'hC3);

        // R5 five-bit send ignores upper bits
        wr(2'd1, 8'h01);
        dec_len = 5;
        reg_addr = 2'd0;
        wr(2'd0, 8'h8A);
        rd(2'd0, r); check("R2 all 8 bits stored", r, 8'h8A);
        repeat (600) @(negedge clk);
        check("R5 one frame", 8'(dec_q.size()), 8'h01);
        if (dec_q.size() > 0) check("R5 five-bit value", dec_q.pop_front(), 8'h0A);

        // R9 receive mode ignores writes
        wr(2'd1, 8'h06);
        reg_addr = 2'd0;
        idle_chk = 1;
        wr(2'd0, 8'h55);
        rd(2'd2, r); check("R9 no pending in receive mode", r, 8'h00);
        reg_addr = 2'd0;
        repeat (200) @(negedge clk);
        rd(2'd0, r); check("R9 data unchanged", r, 8'h8A);
        check("R9 no frame sent", 8'(dec_q.size()), 8'h00);
        idle_chk = 0;
        cmp_en = 0;

        // R7 receive 8 bits
        ic = irq_cnt;
        send_rx(8'h96, 8);
        repeat (10) @(negedge clk);
        rd(2'd0, r); check("R7 received character", r, 8'h96);
        check("R7 irq on reception", 8'(irq_cnt - ic), 8'h01);

        // R11 continuous reception
        send_rx(8'h3B, 8);
        repeat (2) @(negedge clk);
        rd(2'd0, r); check("R11 first of pair", r, 8'h3B);
        send_rx(8'hE4, 8);
        repeat (10) @(negedge clk);
        rd(2'd0, r); check("R11 overwritten by second", r, 8'hE4);

        // R8 six-bit reception masks upper bits
        wr(2'd1, 8'h02);
        reg_addr = 2'd0;
        send_rx(8'hFF, 6);
        repeat (10) @(negedge clk);
        rd(2'd0, r); check("R8 upper bits zero", r, 8'h3F);

        // R10 short glitch discarded
        ic = irq_cnt;
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        check("R10 no irq on glitch", 8'(irq_cnt - ic), 8'h00);
        rd(2'd0, r); check("R10 data unchanged", r, 8'h3F);
        send_rx(8'h15, 6);
        repeat (10) @(negedge clk);
        rd(2'd0, r); check("R10 reception after glitch", r, 8'h15);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule